// File: doc/BRIEF.md
# Byte-Masked Remote Mailbox Sender

This block sits behind a 64-bit write-only command port. Each accepted command turns into one 32-bit store into the register space of another core. The store can leave chosen bytes of the target word untouched. In that case the block reads the target word first, merges the new bytes into it, and writes the result back. When no byte is kept, the block writes the word directly and issues no read.

There are two command kinds, selected by the low 12 bits of the write offset:
- A mailbox command writes one of eight mailbox words at a parameterised base.
- A free-address command writes any 16-bit register address.

The remote side is a 32-bit master port. It carries the target core ID in place of the requester identity. Reads and writes each use a request/acknowledge handshake. Every accepted command gets exactly one response pulse on the command port. The pulse flags an error for bad access sizes and for target cores outside the configured range.

Top module: `mbx_remote_sender`

## Requirements
- R1: After reset, `s_ready` is 1 and `m_rd_req`, `m_wr_req` and `s_resp_valid` are 0.
- R2: A command with `s_bytes` other than 8 gets an error response (`s_resp_err`=1). It makes no remote access.
- R3: Only `s_addr[11:0]` is decoded. Offset `MAIL_OFS` selects a mailbox command and `ANY_OFS` selects a free-address command. Any other offset gets an OK response and no remote access.
- R4: The target core ID is command bits 25:16. An ID of `NUM_CORES` or above gets an error response and no remote access.
- R5: When keep flags 30:27 are all zero, no read is made. One write carries command bits 63:32 unchanged.
- R6: When any keep flag is set, one read comes first, then one write. In the written word, byte i comes from the read data if flag 27+i is set, and from command bits 63:32 otherwise.
- R7: The mailbox command addresses `MBOX_BASE + 0x20 + (cmd & 0x1C)`. The free-address command addresses command bits 15:0.
- R8: `m_cid` equals the decoded target core ID during every remote read and write.
- R9: `s_ready` is low from the acceptance cycle until the single one-cycle response pulse. The response arrives 1 cycle after acceptance plus, for each remote access, one cycle more than its acknowledge wait.
- R10: A read or write request stays asserted with a stable address and core ID until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Command write valid |
| s_ready | output | 1 | Command port idle; a command is accepted when s_valid and s_ready are both high |
| s_addr | input | 16 | Command offset; only the low 12 bits are decoded |
| s_bytes | input | 4 | Access size in bytes; must be 8 |
| s_wdata | input | 64 | Command word |
| s_resp_valid | output | 1 | One-cycle response pulse |
| s_resp_err | output | 1 | Response is an error |
| m_cid | output | 10 | Target core ID for the remote access |
| m_addr | output | 16 | Remote register address |
| m_rd_req | output | 1 | Remote read request |
| m_rd_ack | input | 1 | Remote read acknowledge; m_rd_data is valid with it |
| m_rd_data | input | 32 | Remote read data |
| m_wr_req | output | 1 | Remote write request |
| m_wr_data | output | 32 | Remote write data |
| m_wr_ack | input | 1 | Remote write acknowledge |

## Verification
The bench builds the block with `NUM_CORES`=4, `MBOX_BASE`=0x1000, `MAIL_OFS`=0x048 and `ANY_OFS`=0x158. With four cores, ID 3 is the last valid target, while IDs 4 and 1023 fall outside the range. Both sides of the core-ID bound can therefore be driven from a single 10-bit field. The bench also runs with acknowledge delays of 0, 1 and 2 cycles, which checks that the response latency follows the wait on each access.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_READ  = 2'd1,
    SEQ_WRITE = 2'd2,
    SEQ_DONE  = 2'd3
  } seq_st_e;

  localparam int CMD_W  = 64;
  localparam int WORD_W = 32;
  localparam int CID_W  = 10;
  localparam int RADR_W = 16;
  localparam int LANES  = WORD_W / 8;

  // mailbox word address: base, fixed 0x20 step, word select from bits 4:2
  function automatic logic [RADR_W-1:0] mailbox_addr(input logic [RADR_W-1:0] base,
                                                     input logic [CMD_W-1:0] cmd);
    return base + RADR_W'(16'h0020) + RADR_W'({cmd[4:2], 2'b00});
  endfunction

  function automatic logic [CID_W-1:0] cmd_cid(input logic [CMD_W-1:0] cmd);
    return cmd[25:16];
  endfunction

  function automatic logic [LANES-1:0] cmd_keep(input logic [CMD_W-1:0] cmd);
    return cmd[30:27];
  endfunction

  function automatic logic [WORD_W-1:0] cmd_data(input logic [CMD_W-1:0] cmd);
    return cmd[63:32];
  endfunction

endpackage

// File: rtl/mbx_cmd_decode.sv
module mbx_cmd_decode
  import mbx_pkg::*;
#(
  parameter int          SADDR_W   = 16,
  parameter int          NUM_CORES = 4,
  parameter logic [11:0] MAIL_OFS  = 12'h048,
  parameter logic [11:0] ANY_OFS   = 12'h158,
  parameter logic [15:0] MBOX_BASE = 16'h1000
) (
  input  logic [SADDR_W-1:0] addr,
  input  logic [3:0]         nbytes,
  input  logic [CMD_W-1:0]   cmd,
  output logic               size_ok,
  output logic               is_cmd,
  output logic               cid_ok,
  output logic [CID_W-1:0]   cid,
  output logic [RADR_W-1:0]  tgt_addr,
  output logic [WORD_W-1:0]  data,
  output logic [LANES-1:0]   keep
);
  logic [11:0] off;
  logic        is_mail;
  logic        is_any;
  logic        unused_bits;

  assign off         = addr[11:0];
  assign unused_bits = ^{addr[SADDR_W-1:12], cmd[26], cmd[31]};
  assign is_mail     = (off == MAIL_OFS);
  assign is_any      = (off == ANY_OFS);
  assign is_cmd      = is_mail | is_any;
  assign size_ok     = (nbytes == 4'd8);
  assign cid         = cmd_cid(cmd);
  assign cid_ok      = ({22'd0, cid} < 32'(NUM_CORES));
  assign keep        = cmd_keep(cmd);
  assign data        = cmd_data(cmd);
  assign tgt_addr    = is_mail ? mailbox_addr(MBOX_BASE, cmd) : cmd[15:0];
endmodule

// File: rtl/mbx_byte_merge.sv
module mbx_byte_merge
  import mbx_pkg::*;
(
  input  logic [WORD_W-1:0] old_w,
  input  logic [WORD_W-1:0] new_w,
  input  logic [LANES-1:0]  keep,
  output logic [WORD_W-1:0] merged
);
  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    assign merged[8*gi +: 8] = keep[gi] ? old_w[8*gi +: 8] : new_w[8*gi +: 8];
  end
endmodule

// File: rtl/mbx_seq_fsm.sv
module mbx_seq_fsm
  import mbx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_err,
  input  logic start_skip,
  input  logic need_read,
  input  logic rd_ack,
  input  logic wr_ack,
  output logic ready,
  output logic rd_req,
  output logic wr_req,
  output logic resp_valid,
  output logic resp_err
);
  seq_st_e st_q, st_d;
  logic    err_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SEQ_IDLE:  if (start) begin
                   if (start_err || start_skip) st_d = SEQ_DONE;
                   else if (need_read)          st_d = SEQ_READ;
                   else                         st_d = SEQ_WRITE;
                 end
      SEQ_READ:  if (rd_ack) st_d = SEQ_WRITE;
      SEQ_WRITE: if (wr_ack) st_d = SEQ_DONE;
      SEQ_DONE:  st_d = SEQ_IDLE;
      default:   st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      err_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (start && st_q == SEQ_IDLE) err_q <= start_err;
    end
  end

  assign ready      = (st_q == SEQ_IDLE);
  assign rd_req     = (st_q == SEQ_READ);
  assign wr_req     = (st_q == SEQ_WRITE);
  assign resp_valid = (st_q == SEQ_DONE);
  assign resp_err   = resp_valid & err_q;

  // R9
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid && ready);

  // R6
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));
endmodule

// File: rtl/mbx_remote_sender.sv
module mbx_remote_sender
  import mbx_pkg::*;
#(
  parameter int          NUM_CORES = 4,
  parameter logic [15:0] MBOX_BASE = 16'h1000,
  parameter logic [11:0] MAIL_OFS  = 12'h048,
  parameter logic [11:0] ANY_OFS   = 12'h158
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [15:0] s_addr,
  input  logic [3:0]  s_bytes,
  input  logic [63:0] s_wdata,
  output logic        s_resp_valid,
  output logic        s_resp_err,
  output logic [9:0]  m_cid,
  output logic [15:0] m_addr,
  output logic        m_rd_req,
  input  logic        m_rd_ack,
  input  logic [31:0] m_rd_data,
  output logic        m_wr_req,
  output logic [31:0] m_wr_data,
  input  logic        m_wr_ack
);
  logic              fire;
  logic              size_ok, is_cmd, cid_ok;
  logic [CID_W-1:0]  dec_cid;
  logic [RADR_W-1:0] dec_addr;
  logic [WORD_W-1:0] dec_data;
  logic [LANES-1:0]  dec_keep;
  logic              bad_cid, bad_size, skip_cmd, need_read;
  logic [CID_W-1:0]  cid_q;
  logic [RADR_W-1:0] addr_q;
  logic [WORD_W-1:0] new_q, wdat_q, merged;
  logic [LANES-1:0]  keep_q;

  mbx_cmd_decode #(
    .SADDR_W(16), .NUM_CORES(NUM_CORES), .MAIL_OFS(MAIL_OFS),
    .ANY_OFS(ANY_OFS), .MBOX_BASE(MBOX_BASE)
  ) u_dec (
    .addr(s_addr), .nbytes(s_bytes), .cmd(s_wdata),
    .size_ok(size_ok), .is_cmd(is_cmd), .cid_ok(cid_ok),
    .cid(dec_cid), .tgt_addr(dec_addr), .data(dec_data), .keep(dec_keep)
  );

  assign fire      = s_valid & s_ready;
  assign bad_size  = !size_ok;
  assign skip_cmd  = size_ok & !is_cmd;
  assign bad_cid   = size_ok & is_cmd & !cid_ok;
  assign need_read = |dec_keep;

  mbx_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .start(fire), .start_err(bad_size | bad_cid), .start_skip(skip_cmd),
    .need_read(need_read), .rd_ack(m_rd_ack), .wr_ack(m_wr_ack),
    .ready(s_ready), .rd_req(m_rd_req), .wr_req(m_wr_req),
    .resp_valid(s_resp_valid), .resp_err(s_resp_err)
  );

  mbx_byte_merge u_merge (
    .old_w(m_rd_data), .new_w(new_q), .keep(keep_q), .merged(merged)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cid_q  <= '0;
      addr_q <= '0;
      new_q  <= '0;
      wdat_q <= '0;
      keep_q <= '0;
    end else if (fire) begin
      cid_q  <= dec_cid;
      addr_q <= dec_addr;
      new_q  <= dec_data;
      wdat_q <= dec_data;
      keep_q <= dec_keep;
    end else if (m_rd_req && m_rd_ack) begin
      wdat_q <= merged;
    end
  end

  assign m_cid     = cid_q;
  assign m_addr    = addr_q;
  assign m_wr_data = wdat_q;

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_rd_req && !m_rd_ack |=> m_rd_req && $stable(m_addr) && $stable(m_cid));

  // R10
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_wr_req && !m_wr_ack |=> m_wr_req && $stable(m_wr_data) && $stable(m_addr));

  // R4
  bad_cid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && bad_cid |=> s_resp_valid && s_resp_err && !m_rd_req && !m_wr_req);

  // R5
  direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && size_ok && is_cmd && cid_ok && dec_keep == '0 |=> m_wr_req && !m_rd_req);

  // R9
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !s_ready);
endmodule

// File: tb/mbx_remote_sender_test.sv
module mbx_remote_sender_test;
  localparam int          NCORES = 4;
  localparam logic [15:0] BASE   = 16'h1000;
  localparam logic [11:0] MOFS   = 12'h048;
  localparam logic [11:0] AOFS   = 12'h158;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [15:0] s_addr = '0;
  logic [3:0]  s_bytes = 4'd8;
  logic [63:0] s_wdata = '0;
  logic        s_resp_valid, s_resp_err;
  logic [9:0]  m_cid;
  logic [15:0] m_addr;
  logic        m_rd_req, m_wr_req;
  logic        m_rd_ack = 1'b0, m_wr_ack = 1'b0;
  logic [31:0] m_rd_data = '0;
  logic [31:0] m_wr_data;

  int n_checks = 0;
  int n_fails  = 0;
  int ack_dly  = 0;
  int wcnt     = 0;
  int cyc      = 0;
  bit busy     = 0;

  logic [31:0] mem [int];
  bit          exp_rd, exp_wr, seen_rd, seen_wr;
  logic [9:0]  exp_cid;
  logic [15:0] exp_addr;
  logic [31:0] exp_new;
  logic [3:0]  exp_keep;

  always #10 clk = ~clk;

  mbx_remote_sender #(
    .NUM_CORES(NCORES), .MBOX_BASE(BASE), .MAIL_OFS(MOFS), .ANY_OFS(AOFS)
  ) uut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_addr(s_addr), .s_bytes(s_bytes), .s_wdata(s_wdata),
    .s_resp_valid(s_resp_valid), .s_resp_err(s_resp_err),
    .m_cid(m_cid), .m_addr(m_addr), .m_rd_req(m_rd_req), .m_rd_ack(m_rd_ack),
    .m_rd_data(m_rd_data), .m_wr_req(m_wr_req), .m_wr_data(m_wr_data),
    .m_wr_ack(m_wr_ack)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int key(input logic [9:0] c, input logic [15:0] a);
    return {6'd0, c, a};
  endfunction

  function automatic logic [31:0] peek(input logic [9:0] c, input logic [15:0] a);
    if (mem.exists(key(c, a))) return mem[key(c, a)];
    return (key(c, a) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  // remote responder and reference model, every cycle at the falling edge
  always @(negedge clk) begin
    m_rd_ack = 1'b0;
    m_wr_ack = 1'b0;
    cyc++;
    if (rst_n) begin
      check(s_ready == !busy, "R9", "ready vs busy", 64'(s_ready), 64'(!busy));
      if (m_rd_req) begin
        if (wcnt == ack_dly) begin
          seen_rd = 1;
          check(exp_rd, "R5", "unexpected read", 64'(m_rd_req), 64'(exp_rd));
          check(m_addr == exp_addr, "R7", "read addr", 64'(m_addr), 64'(exp_addr));
          check(m_cid == exp_cid, "R8", "read cid", 64'(m_cid), 64'(exp_cid));
          m_rd_data = peek(m_cid, m_addr);
          m_rd_ack  = 1'b1;
          wcnt = 0;
        end else wcnt++;
      end else if (m_wr_req) begin
        if (wcnt == ack_dly) begin
          logic [31:0] old_v, want;
          old_v = peek(exp_cid, exp_addr);
          for (int i = 0; i < 4; i++)
            want[8*i +: 8] = exp_keep[i] ? old_v[8*i +: 8] : exp_new[8*i +: 8];
          seen_wr = 1;
          check(exp_wr, "R2", "unexpected write", 64'(m_wr_req), 64'(exp_wr));
          check(m_addr == exp_addr, "R7", "write addr", 64'(m_addr), 64'(exp_addr));
          check(m_cid == exp_cid, "R8", "write cid", 64'(m_cid), 64'(exp_cid));
          check(m_wr_data == want, "R6", "write data", 64'(m_wr_data), 64'(want));
          mem[key(m_cid, m_addr)] = m_wr_data;
          m_wr_ack = 1'b1;
          wcnt = 0;
        end else wcnt++;
      end else wcnt = 0;
    end
    if (cyc > 100000) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  task automatic send(input logic [15:0] a, input logic [3:0] nb, input logic [63:0] v,
                      input string tag);
    logic [11:0] off;
    bit          cmd_ok, err;
    int          lat, want_lat;
    off      = a[11:0];
    exp_cid  = v[25:16];
    exp_keep = v[30:27];
    exp_new  = v[63:32];
    exp_addr = (off == MOFS) ? BASE + 16'h20 + (v[15:0] & 16'h1C) : v[15:0];
    err      = (nb != 4'd8) || ((off == MOFS || off == AOFS) && exp_cid >= NCORES);
    cmd_ok   = !err && (off == MOFS || off == AOFS);
    exp_rd   = cmd_ok && (exp_keep != 0);
    exp_wr   = cmd_ok;
    seen_rd  = 0;
    seen_wr  = 0;
    want_lat = 1 + (exp_rd ? ack_dly + 1 : 0) + (exp_wr ? ack_dly + 1 : 0);
    @(negedge clk);
    s_addr = a; s_bytes = nb; s_wdata = v; s_valid = 1'b1;
    @(posedge clk);
    busy = 1;
    @(negedge clk);
    s_valid = 1'b0;
    lat = 1;
    while (!s_resp_valid && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    check(s_resp_valid, tag, "response seen", 64'(s_resp_valid), 64'd1);
    check(s_resp_err == err, tag, "response err", 64'(s_resp_err), 64'(err));
    check(lat == want_lat, "R9", "latency", 64'(lat), 64'(want_lat));
    check(seen_rd == exp_rd, tag, "read issued", 64'(seen_rd), 64'(exp_rd));
    check(seen_wr == exp_wr, tag, "write issued", 64'(seen_wr), 64'(exp_wr));
    @(posedge clk);
    busy = 0;
  endtask

  function automatic logic [63:0] mk(input logic [31:0] d, input logic [3:0] k,
                                     input logic [9:0] c, input logic [15:0] lo);
    return {d, 1'b0, k, 1'b0, c, lo};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(s_ready == 1'b1, "R1", "ready in reset", 64'(s_ready), 64'd1);
    check(!m_rd_req && !m_wr_req, "R1", "no requests", 64'({m_rd_req, m_wr_req}), 64'd0);
    check(!s_resp_valid, "R1", "no response", 64'(s_resp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(s_ready == 1'b1, "R1", "ready after reset", 64'(s_ready), 64'd1);

    // R5 R7 R8: direct writes
    ack_dly = 0;
    send({4'h0, AOFS}, 4'd8, mk(32'hDEADBEEF, 4'h0, 10'd2, 16'h0040), "R5");
    send({4'h0, MOFS}, 4'd8, mk(32'h01234567, 4'h0, 10'd1, 16'hFFF4), "R7");
    // R6 masked merges at different ack delays
    send({4'h0, AOFS}, 4'd8, mk(32'hAABBCCDD, 4'b0101, 10'd2, 16'h0040), "R6");
    ack_dly = 2;
    send({4'h0, MOFS}, 4'd8, mk(32'h11112222, 4'b1111, 10'd0, 16'h0008), "R6");
    ack_dly = 1;
    send({4'h0, AOFS}, 4'd8, mk(32'h99887766, 4'b1000, 10'd3, 16'h7FFC), "R6");
    send({4'h0, MOFS}, 4'd8, mk(32'h55AA55AA, 4'b0010, 10'd1, 16'h0014), "R6");
    // R4 out-of-range core IDs
    send({4'h0, AOFS}, 4'd8, mk(32'hCAFEF00D, 4'h0, 10'd4, 16'h0010), "R4");
    send({4'h0, MOFS}, 4'd8, mk(32'hCAFEF00D, 4'b0110, 10'd1023, 16'h0010), "R4");
    // R2 wrong access size
    ack_dly = 0;
    send({4'h0, AOFS}, 4'd4, mk(32'h12345678, 4'h0, 10'd0, 16'h0020), "R2");
    // R3 offset decode: unknown offset ignored, upper address bits masked
    send(16'h0100, 4'd8, mk(32'h12345678, 4'h0, 10'd0, 16'h0020), "R3");
    send({4'hF, AOFS}, 4'd8, mk(32'h0BADCAFE, 4'h0, 10'd3, 16'h0020), "R3");
    send({4'hA, MOFS}, 4'd8, mk(32'h76543210, 4'b1001, 10'd3, 16'h001C), "R3");

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule